// File: doc/BRIEF.md
# Cascadable Up/Down Loadable Counter

This block is a synchronous binary counter of parameterised width. It has one count-enable input for counting up and another for counting down, a parallel load, and a synchronous clear. On every rising clock edge it takes exactly one action. The clear wins over everything else. Load comes next. After that comes an up step, then a down step, and if nothing applies the count holds.

Beside the count, the block drives two terminal-count flags and two cascade enables. The terminal-count flags report the all-ones and all-zeros states. Each cascade enable is that flag ANDed with the matching direction enable. All four are combinational.

To build a wider counter, the stages share clock, clear and load. Each stage's cascade enables drive the direction enables of the next, more significant stage. The terminal counts of the whole chain are the AND of the per-stage flags. A carry or borrow therefore reaches a higher stage in the same cycle. It travels only through AND gates and never through a register-to-register ripple path.

Top module: `casc_updown_counter`

## Requirements
- R1: With `rst` high at a rising edge, `count` becomes all zeros, whatever the values of `load`, `en_up`, `en_dn` and `din`.
- R2: With `rst` low and `load` high at a rising edge, `count` takes the value of `din`, whatever the state of both enables.
- R3: With `rst` and `load` low and `en_up` high, `count` increases by one at the rising edge, wrapping from all ones to all zeros.
- R4: With `rst`, `load` and `en_up` low and `en_dn` high, `count` decreases by one at the rising edge, wrapping from all zeros to all ones.
- R5: With `rst`, `load`, `en_up` and `en_dn` all low, `count` keeps its value across the rising edge.
- R6: With both `en_up` and `en_dn` high (and `rst`, `load` low), `count` increases by one. The cascade outputs are not specified for that case.
- R7: `tc_up` is 1 exactly when every bit of `count` is 1, independent of `en_up`.
- R8: `tc_dn` is 1 exactly when every bit of `count` is 0, independent of `en_dn`.
- R9: `cas_up` equals `tc_up` AND `en_up`, and `cas_dn` equals `tc_dn` AND `en_dn`. Both follow their inputs in the same cycle, with no clock edge in between.
- R10: Two stages chained through `cas_up`/`cas_dn` into the upper stage's `en_up`/`en_dn`, sharing `clk`, `rst` and `load`, behave as one counter of twice the width. This holds when counting up, counting down (including wrap in both directions) and loading. The wide terminal counts are the AND of the stage flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every action occurs on its rising edge |
| rst | input | 1 | Synchronous clear, active high, highest priority |
| load | input | 1 | Parallel load request, active high |
| en_up | input | 1 | Count-up enable, or cascade-up input from a lower stage |
| en_dn | input | 1 | Count-down enable, or cascade-down input from a lower stage |
| din | input | W | Parallel load value |
| count | output | W | Current count |
| tc_up | output | 1 | High when the count is all ones |
| tc_dn | output | 1 | High when the count is all zeros |
| cas_up | output | 1 | Up cascade enable for the next stage |
| cas_dn | output | 1 | Down cascade enable for the next stage |

## Verification
An incorrect stored value shows on `count` at the very next rising edge. It also shows on `tc_up` or `tc_dn` in the same cycle, because those flags decode the register with no delay. A wrong priority or wrong step direction is visible one edge after the offending control combination. In a chain, a cascade fault does not show on the lower stage's count. It shows as the upper stage's count stepping at the wrong time, one edge after the lower stage passes through all ones or all zeros. The bench therefore compares the double-width count against a reference on every edge.

// File: rtl/cudc_pkg.sv
package cudc_pkg;

    // One action per rising edge, chosen by priority.
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_CLEAR = 3'd1,
        OP_LOAD  = 3'd2,
        OP_INC   = 3'd3,
        OP_DEC   = 3'd4
    } step_op_e;

    // Control inputs sampled at the edge.
    typedef struct packed {
        logic clear;
        logic load;
        logic up;
        logic dn;
    } ctl_s;

    // Terminal and cascade flags of one stage.
    typedef struct packed {
        logic tc_up;
        logic tc_dn;
        logic cas_up;
        logic cas_dn;
    } flags_s;

    // Priority: clear, load, up (also wins when both enables are set), down.
    function automatic step_op_e pick_op(input ctl_s c);
        if (c.clear)     return OP_CLEAR;
        else if (c.load) return OP_LOAD;
        else if (c.up)   return OP_INC;
        else if (c.dn)   return OP_DEC;
        else             return OP_HOLD;
    endfunction

endpackage

// File: rtl/cudc_op_decode.sv
module cudc_op_decode
    import cudc_pkg::*;
(
    input  ctl_s     ctl,
    output step_op_e op
);
    always_comb begin
        op = pick_op(ctl);
    end
endmodule

// File: rtl/cudc_state_reg.sv
module cudc_state_reg
    import cudc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  step_op_e     op,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] q_nxt;

    // Modulo 2**W arithmetic: wrap comes from dropping the carry.
    always_comb begin
        unique case (op)
            OP_CLEAR: q_nxt = ZERO;
            OP_LOAD:  q_nxt = din;
            OP_INC:   q_nxt = q + ONE;
            OP_DEC:   q_nxt = q - ONE;
            default:  q_nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        q <= q_nxt;
    end
endmodule

// File: rtl/cudc_term_detect.sv
module cudc_term_detect
    import cudc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] q,
    input  logic         en_up,
    input  logic         en_dn,
    output flags_s       flags
);
    always_comb begin
        flags.tc_up  = &q;
        flags.tc_dn  = ~|q;
        flags.cas_up = flags.tc_up & en_up;
        flags.cas_dn = flags.tc_dn & en_dn;
    end
endmodule

// File: rtl/casc_updown_counter.sv
module casc_updown_counter
    import cudc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         en_up,
    input  logic         en_dn,
    input  logic [W-1:0] din,
    output logic [W-1:0] count,
    output logic         tc_up,
    output logic         tc_dn,
    output logic         cas_up,
    output logic         cas_dn
);
    ctl_s     ctl;
    step_op_e op;
    flags_s   flags;

    assign ctl = '{clear: rst, load: load, up: en_up, dn: en_dn};

    cudc_op_decode u_dec (
        .ctl (ctl),
        .op  (op)
    );

    cudc_state_reg #(.W(W)) u_reg (
        .clk (clk),
        .op  (op),
        .din (din),
        .q   (count)
    );

    cudc_term_detect #(.W(W)) u_term (
        .q     (count),
        .en_up (en_up),
        .en_dn (en_dn),
        .flags (flags)
    );

    assign tc_up  = flags.tc_up;
    assign tc_dn  = flags.tc_dn;
    assign cas_up = flags.cas_up;
    assign cas_dn = flags.cas_dn;
endmodule

// File: rtl/casc_updown_counter_chk.sv
module casc_updown_counter_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         load,
    input logic         en_up,
    input logic         en_dn,
    input logic [W-1:0] din,
    input logic [W-1:0] count,
    input logic         tc_up,
    input logic         tc_dn,
    input logic         cas_up,
    input logic         cas_dn
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic         seen = 1'b0;
    logic [W-1:0] inc_v;
    logic [W-1:0] dec_v;

    always_ff @(posedge clk) seen <= 1'b1;

    assign inc_v = count + ONE;
    assign dec_v = count - ONE;

    // R1
    a_r1_clear_wins: assert property (@(posedge clk) disable iff (!seen)
        rst |=> count == '0);
    // R2
    a_r2_load_takes_din: assert property (@(posedge clk) disable iff (rst || !seen)
        load |=> count == $past(din));
    // R3, R6
    a_r3_up_step: assert property (@(posedge clk) disable iff (rst || !seen)
        (!load && en_up) |=> count == $past(inc_v));
    // R4
    a_r4_down_step: assert property (@(posedge clk) disable iff (rst || !seen)
        (!load && !en_up && en_dn) |=> count == $past(dec_v));
    // R5
    a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst || !seen)
        (!load && !en_up && !en_dn) |=> $stable(count));
    // R7
    a_r7_tc_up_all_ones: assert property (@(posedge clk) disable iff (rst || !seen)
        tc_up == (count == '1));
    // R8
    a_r8_tc_dn_all_zero: assert property (@(posedge clk) disable iff (rst || !seen)
        tc_dn == (count == '0));
    // R9
    a_r9_cas_up: assert property (@(posedge clk) disable iff (rst || !seen)
        !(en_up && en_dn) |-> cas_up == (tc_up && en_up));
    // R9
    a_r9_cas_dn: assert property (@(posedge clk) disable iff (rst || !seen)
        !(en_up && en_dn) |-> cas_dn == (tc_dn && en_dn));
endmodule

bind casc_updown_counter casc_updown_counter_chk #(.W(W)) u_chk (.*);

// File: tb/casc_updown_counter_test.sv
`timescale 1ns/1ps
module casc_updown_counter_test;
    localparam int W  = 4;
    localparam int WW = 2 * W;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst, load, en_up, en_dn;
    logic [WW-1:0] din;
    logic [W-1:0]  q_lo, q_hi;
    logic          tcu_lo, tcd_lo, cu_lo, cd_lo;
    logic          tcu_hi, tcd_hi, cu_hi, cd_hi;

    casc_updown_counter #(.W(W)) uut (
        .clk(clk), .rst(rst), .load(load), .en_up(en_up), .en_dn(en_dn),
        .din(din[W-1:0]), .count(q_lo), .tc_up(tcu_lo), .tc_dn(tcd_lo),
        .cas_up(cu_lo), .cas_dn(cd_lo)
    );

    casc_updown_counter #(.W(W)) upper (
        .clk(clk), .rst(rst), .load(load), .en_up(cu_lo), .en_dn(cd_lo),
        .din(din[WW-1:W]), .count(q_hi), .tc_up(tcu_hi), .tc_dn(tcd_hi),
        .cas_up(cu_hi), .cas_dn(cd_hi)
    );

    int            n_chk  = 0;
    int            n_fail = 0;
    logic          done   = 1'b0;
    logic [WW-1:0] model  = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a negedge; drives, takes one rising edge, updates the model, returns at the next negedge.
    task automatic step(input logic r, input logic l, input logic u, input logic d,
                        input logic [WW-1:0] dv);
        rst = r; load = l; en_up = u; en_dn = d; din = dv;
        @(posedge clk);
        if (r)      model = '0;
        else if (l) model = dv;
        else if (u) model = model + 1'b1;
        else if (d) model = model - 1'b1;
        @(negedge clk);
    endtask

    task automatic idle();
        rst = 1'b0; load = 1'b0; en_up = 1'b0; en_dn = 1'b0;
    endtask

    task automatic check_wide(input string req);
        chk(req, 32'({q_hi, q_lo}), 32'(model));
        chk({req, " wide tc_up"}, 32'(tcu_lo & tcu_hi), 32'(model == '1));
        chk({req, " wide tc_dn"}, 32'(tcd_lo & tcd_hi), 32'(model == '0));
    endtask

    task automatic t_reset();
        step(1'b1, 1'b1, 1'b1, 1'b0, 8'h5A);
        check_wide("R1 reset with load and up");
        chk("R7 tc_up low after reset", 32'(tcu_lo), 32'd0);
        chk("R8 tc_dn high after reset", 32'(tcd_lo), 32'd1);
    endtask

    task automatic t_load();
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'hA5);
        chk("R2 load with both enables", 32'({q_hi, q_lo}), 32'h0A5);
        step(1'b0, 1'b1, 1'b0, 1'b1, 8'h3C);
        check_wide("R2 load with down enable");
    endtask

    task automatic t_hold();
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b0, 1'b0, 1'b0, 8'hFF);
            check_wide("R5 hold");
        end
    endtask

    task automatic t_up_wrap();
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'hFD);
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
            check_wide("R3 R10 chained up count");
        end
        chk("R3 wrap to 02", 32'({q_hi, q_lo}), 32'h02);
    endtask

    task automatic t_down_wrap();
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'h02);
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
            check_wide("R4 R10 chained down count");
        end
        chk("R4 wrap to FD", 32'({q_hi, q_lo}), 32'hFD);
        // Borrow across the stage boundary: 0x10 down to 0x0F.
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'h10);
        step(1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
        check_wide("R10 borrow into upper stage");
    endtask

    task automatic t_both();
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'h37);
        step(1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
        chk("R6 both enables count up", 32'(q_lo), 32'h8);
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'h37);
    endtask

    task automatic t_reset_over_load();
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'hC3);
        step(1'b1, 1'b1, 1'b0, 1'b1, 8'h99);
        check_wide("R1 reset over load");
    endtask

    // Combinational flags checked in the low phase, with no edge in between.
    task automatic t_flags();
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'h0F);
        idle();
        #1;
        chk("R7 tc_up without en_up", 32'(tcu_lo), 32'd1);
        chk("R9 cas_up low without en_up", 32'(cu_lo), 32'd0);
        en_up = 1'b1;
        #0.5;
        chk("R9 cas_up follows en_up", 32'(cu_lo), 32'd1);
        chk("R8 tc_dn low at 0F", 32'(tcd_lo), 32'd0);
        idle();
        @(negedge clk);
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'hF0);
        idle();
        #1;
        chk("R8 tc_dn without en_dn", 32'(tcd_lo), 32'd1);
        chk("R9 cas_dn low without en_dn", 32'(cd_lo), 32'd0);
        en_dn = 1'b1;
        #0.5;
        chk("R9 cas_dn follows en_dn", 32'(cd_lo), 32'd1);
        chk("R7 upper tc_up at F0", 32'(tcu_hi), 32'd1);
        idle();
        @(negedge clk);
        check_wide("R5 flags probe left count unchanged");
    endtask

    initial begin
        idle();
        din = '0;
        @(negedge clk);
        t_reset();
        t_load();
        t_hold();
        t_up_wrap();
        t_down_wrap();
        t_both();
        t_reset_over_load();
        t_flags();
        idle();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule